// File: doc/BRIEF.md
# Programmable Input Glitch Filter

This block cleans up one asynchronous timing input before the rest of the chip uses it. The raw line is first brought into the system clock domain. It then goes through a debounce stage that copies a new level to the output only after that level has been seen on a given number of back-to-back sample strobes. A single sample at the old level restarts the count, so short glitches never reach the output. Rising and falling changes are treated the same way.

A two-bit selector picks one of four settings. Each setting pairs a sample rate with a required run length. Three settings are fixed: fast sampling with a short run, fast sampling with a long run, and slow sampling from a divided timebase. The fourth setting takes its divider and run length from two register inputs. An enable input bypasses the filter, so the output then follows the synchronized input. The input is a level, not a stream of data words, so it has no valid/ready handshake and cannot be held back. Every pin is a plain control or level signal.

Top module: `glitch_filter_chan`

## Requirements
- R1: While synchronous reset is asserted, and on the first cycle after it is released, `filt_out` is 0 and the run counter is cleared.
- R2: With `filt_en` = 0, `filt_out` follows `raw_in` with a delay of exactly three rising clock edges (two synchronizer flops plus the output register), and no samples are counted.
- R3: With `filt_en` = 1, a new input level is copied to `filt_out` once it has been sampled on N consecutive strobes. In the short setting (`mode_sel` = 2'b00: a strobe every clock, N = SHORT_COUNT = 9), `filt_out` changes on the 11th rising edge after the input changes. A 9-cycle pulse passes.
- R4: A sample at the current output level clears the run counter. A pulse shorter than N samples (8 cycles in the short setting), or a run that is broken by a one-cycle glitch back to the old level, never reaches `filt_out`.
- R5: A change from high to low is filtered with the same count and the same latency as a change from low to high.
- R6: Medium setting (`mode_sel` = 2'b01): a strobe every clock and N = MED_COUNT = 512. A 512-cycle pulse passes and a 511-cycle pulse is rejected.
- R7: Slow setting (`mode_sel` = 2'b10): one strobe every SLOW_DIV clocks (800 by default, which gives 100 kHz from 80 MHz) and N = SLOW_COUNT (256 by default). A pulse of N*SLOW_DIV cycles always passes. A pulse of (N-1)*SLOW_DIV cycles is always rejected.
- R8: Custom setting (`mode_sel` = 2'b11): one strobe every `cust_div` clocks and N = `cust_count`. A value of 0 in either register acts as 1.
- R9: A change of `filt_en` or `mode_sel` clears both the run counter and the strobe divider, and `filt_out` keeps its present level. A flip after the change needs a full run of N samples, counted from the edge after the change.
- R10: While enabled, `filt_out` changes only on a cycle that carries a sample strobe. A change always moves `filt_out` to the synchronized input level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (80 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| filt_en | input | 1 | 1 = filter active, 0 = pass through after synchronization |
| mode_sel | input | 2 | 00 short, 01 medium, 10 slow, 11 custom |
| cust_div | input | DIV_W | Clocks per sample strobe in custom setting (0 acts as 1) |
| cust_count | input | CNT_W | Consecutive samples needed in custom setting (0 acts as 1) |
| raw_in | input | 1 | Asynchronous raw input line |
| filt_out | output | 1 | Filtered level |

## Verification
The assertions take for granted that `filt_en` and `mode_sel` are held steady between deliberate setting changes. They also assume that `cust_div` and `cust_count` are changed only while the input is idle, because a change to those two registers does not clear the counter or the divider. The stimulus follows both rules: every setting change is followed by several idle cycles before a pulse is sent, and the custom registers are written while the input agrees with the output. Also, `raw_in` only moves on falling clock edges, so the synchronizer never sees a level that changes during a sample and the pulse widths in cycles are exact.

// File: rtl/glf_pkg.sv
package glf_pkg;

  typedef enum logic [1:0] {
    GLF_SHORT  = 2'b00,
    GLF_MEDIUM = 2'b01,
    GLF_SLOW   = 2'b10,
    GLF_CUSTOM = 2'b11
  } glf_mode_e;

  typedef struct packed {
    logic      en;
    glf_mode_e mode;
  } glf_cfg_t;

endpackage

// File: rtl/glf_sync.sv
module glf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/glf_strobe.sv
module glf_strobe #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             stb
);
  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] phase;

  // a divide value of zero behaves as one
  assign lim = (div == '0) ? DIV_W'(1) : div;
  assign stb = (phase >= lim - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr)  phase <= '0;
    else if (stb)    phase <= '0;
    else             phase <= phase + DIV_W'(1);
  end
endmodule

// File: rtl/glf_settle.sv
module glf_settle #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic             stb,
  input  logic             lvl,
  input  logic [CNT_W-1:0] need,
  output logic             out,
  output logic [CNT_W-1:0] run
);
  logic [CNT_W-1:0] need_eff;
  logic             last_sample;

  assign need_eff    = (need == '0) ? CNT_W'(1) : need;
  assign last_sample = (run >= need_eff - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      out <= 1'b0;
      run <= '0;
    end else if (!en) begin
      out <= lvl;
      run <= '0;
    end else if (clr || (lvl == out)) begin
      run <= '0;
    end else if (stb) begin
      if (last_sample) begin
        out <= lvl;
        run <= '0;
      end else begin
        run <= run + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/glitch_filter_chan.sv
module glitch_filter_chan
  import glf_pkg::*;
#(
  parameter int SHORT_COUNT = 9,
  parameter int MED_COUNT   = 512,
  parameter int SLOW_DIV    = 800,
  parameter int SLOW_COUNT  = 256,
  parameter int DIV_W       = 16,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             filt_en,
  input  logic [1:0]       mode_sel,
  input  logic [DIV_W-1:0] cust_div,
  input  logic [CNT_W-1:0] cust_count,
  input  logic             raw_in,
  output logic             filt_out
);
  localparam logic [DIV_W-1:0] FAST_DIV_V   = DIV_W'(1);
  localparam logic [DIV_W-1:0] SLOW_DIV_V   = DIV_W'(SLOW_DIV);
  localparam logic [CNT_W-1:0] SHORT_CNT_V  = CNT_W'(SHORT_COUNT);
  localparam logic [CNT_W-1:0] MED_CNT_V    = CNT_W'(MED_COUNT);
  localparam logic [CNT_W-1:0] SLOW_CNT_V   = CNT_W'(SLOW_COUNT);

  logic             sync_lvl;
  logic             smp_stb;
  logic             cfg_chg;
  logic [CNT_W-1:0] run_cnt;
  logic [DIV_W-1:0] div_sel;
  logic [CNT_W-1:0] need_sel;
  glf_cfg_t         cfg_now;
  glf_cfg_t         cfg_q;

  assign cfg_now.en   = filt_en;
  assign cfg_now.mode = glf_mode_e'(mode_sel);

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= cfg_now;
    else     cfg_q <= cfg_now;
  end

  assign cfg_chg = (cfg_now != cfg_q);

  always_comb begin
    unique case (cfg_now.mode)
      GLF_SHORT:  begin div_sel = FAST_DIV_V; need_sel = SHORT_CNT_V; end
      GLF_MEDIUM: begin div_sel = FAST_DIV_V; need_sel = MED_CNT_V;   end
      GLF_SLOW:   begin div_sel = SLOW_DIV_V; need_sel = SLOW_CNT_V;  end
      default:    begin div_sel = cust_div;   need_sel = cust_count;  end
    endcase
  end

  glf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (raw_in),
    .q_out (sync_lvl)
  );

  glf_strobe #(.DIV_W(DIV_W)) u_strobe (
    .clk (clk),
    .rst (rst),
    .clr (cfg_chg),
    .div (div_sel),
    .stb (smp_stb)
  );

  glf_settle #(.CNT_W(CNT_W)) u_settle (
    .clk  (clk),
    .rst  (rst),
    .en   (filt_en),
    .clr  (cfg_chg),
    .stb  (smp_stb),
    .lvl  (sync_lvl),
    .need (need_sel),
    .out  (filt_out),
    .run  (run_cnt)
  );
endmodule

// File: rtl/glf_checker.sv
module glf_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             filt_en,
  input logic             cfg_chg,
  input logic             stb,
  input logic             sync_lvl,
  input logic             filt_out,
  input logic [CNT_W-1:0] cnt
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!filt_out && cnt == '0));

  a_r2_bypass_follow: assert property (@(posedge clk) disable iff (rst)
    !filt_en |=> (filt_out == $past(sync_lvl)));

  a_r4_agree_clears: assert property (@(posedge clk) disable iff (rst)
    (filt_en && sync_lvl == filt_out) |=> (cnt == '0));

  a_r9_change_clears: assert property (@(posedge clk) disable iff (rst)
    (filt_en && cfg_chg) |=> (cnt == '0 && $stable(filt_out)));

  a_r10_flip_on_strobe: assert property (@(posedge clk) disable iff (rst)
    (filt_en && !stb) |=> $stable(filt_out));

  a_r10_flip_to_input: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_out) |-> (filt_out == $past(sync_lvl)));
endmodule

bind glitch_filter_chan glf_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .filt_en  (filt_en),
  .cfg_chg  (cfg_chg),
  .stb      (smp_stb),
  .sync_lvl (sync_lvl),
  .filt_out (filt_out),
  .cnt      (run_cnt)
);

// File: tb/tb_glitch_filter_chan.sv
module tb_glitch_filter_chan;
  localparam int CLK_PERIOD = 10;
  localparam int T_DIV      = 8;
  localparam int T_CNT      = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        filt_en = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic [15:0] cust_div = 16'd1;
  logic [15:0] cust_count = 16'd1;
  logic        raw_in = 1'b0;
  logic        filt_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  glitch_filter_chan #(.SLOW_DIV(T_DIV), .SLOW_COUNT(T_CNT)) dut (
    .clk(clk), .rst(rst), .filt_en(filt_en), .mode_sel(mode_sel),
    .cust_div(cust_div), .cust_count(cust_count),
    .raw_in(raw_in), .filt_out(filt_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic en, input logic [1:0] m);
    filt_en  = en;
    mode_sel = m;
    wait_n(4);
  endtask

  // drive the opposite level for w cycles, restore, watch for any output move
  task automatic pulse(input int w, input int settle, output bit moved);
    logic base, init;
    base  = raw_in;
    init  = filt_out;
    moved = 1'b0;
    raw_in = ~base;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (filt_out != init) moved = 1'b1;
    end
    raw_in = base;
    for (int i = 0; i < settle; i++) begin
      @(negedge clk);
      if (filt_out != init) moved = 1'b1;
    end
  endtask

  task automatic t_reset;
    wait_n(1);
    chk("R1 output during reset", filt_out, 0);
    rst = 1'b0;
    wait_n(1);
    chk("R1 output after reset", filt_out, 0);
  endtask

  task automatic t_bypass;
    set_cfg(1'b0, 2'b00);
    raw_in = 1'b1;
    wait_n(2);
    chk("R2 bypass before third edge", filt_out, 0);
    wait_n(1);
    chk("R2 bypass at third edge", filt_out, 1);
    raw_in = 1'b0;
    wait_n(3);
    chk("R2 bypass falling", filt_out, 0);
    wait_n(2);
  endtask

  task automatic t_short_latency;
    set_cfg(1'b1, 2'b00);
    raw_in = 1'b1;
    wait_n(10);
    chk("R3 rise not before edge 11", filt_out, 0);
    wait_n(1);
    chk("R3 rise at edge 11", filt_out, 1);
    wait_n(3);
    raw_in = 1'b0;
    wait_n(10);
    chk("R5 fall not before edge 11", filt_out, 1);
    wait_n(1);
    chk("R5 fall at edge 11", filt_out, 0);
    wait_n(3);
  endtask

  task automatic t_short_widths;
    bit mv;
    pulse(8, 20, mv);
    chk("R4 8-cycle pulse rejected", mv, 0);
    pulse(9, 20, mv);
    chk("R3 9-cycle pulse passes", mv, 1);
    chk("R5 returns low after pass", filt_out, 0);
  endtask

  task automatic t_glitch;
    bit mv;
    logic init;
    init = filt_out;
    mv = 1'b0;
    raw_in = 1'b1; wait_n(6);
    raw_in = 1'b0; wait_n(1);
    raw_in = 1'b1; wait_n(6);
    raw_in = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (filt_out != init) mv = 1'b1;
    end
    chk("R4 broken run not propagated", mv, 0);
  endtask

  task automatic t_medium;
    bit mv;
    set_cfg(1'b1, 2'b01);
    pulse(511, 20, mv);
    chk("R6 511-cycle pulse rejected", mv, 0);
    pulse(512, 530, mv);
    chk("R6 512-cycle pulse passes", mv, 1);
    chk("R6 settles low", filt_out, 0);
  endtask

  task automatic t_slow;
    bit mv;
    set_cfg(1'b1, 2'b10);
    pulse((T_CNT - 1) * T_DIV, 3 * T_DIV, mv);
    chk("R7 (N-1)*DIV pulse rejected", mv, 0);
    pulse(T_CNT * T_DIV, (T_CNT + 2) * T_DIV, mv);
    chk("R7 R10 N*DIV pulse passes", mv, 1);
    chk("R7 settles low", filt_out, 0);
  endtask

  task automatic t_custom;
    bit mv;
    cust_div   = 16'd3;
    cust_count = 16'd5;
    set_cfg(1'b1, 2'b11);
    pulse(12, 24, mv);
    chk("R8 custom short pulse rejected", mv, 0);
    pulse(15, 30, mv);
    chk("R8 custom full pulse passes", mv, 1);
    cust_div   = 16'd0;
    cust_count = 16'd0;
    wait_n(2);
    pulse(1, 8, mv);
    chk("R8 zero registers act as one", mv, 1);
    chk("R8 settles low", filt_out, 0);
  endtask

  task automatic t_cfg_clear;
    set_cfg(1'b1, 2'b00);
    raw_in = 1'b1;
    wait_n(6);
    cust_div   = 16'd1;
    cust_count = 16'd9;
    mode_sel   = 2'b11;
    wait_n(9);
    chk("R9 change restarts run", filt_out, 0);
    wait_n(1);
    chk("R9 full run after change", filt_out, 1);
    mode_sel = 2'b00;
    wait_n(3);
    chk("R9 level kept across change", filt_out, 1);
    raw_in = 1'b0;
    wait_n(15);
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_short_latency();
    t_short_widths();
    t_glitch();
    t_medium();
    t_slow();
    t_custom();
    t_cfg_clear();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule